// File: doc/BRIEF.md
# Binary32 Operand Classifier and NaN Quieter

This combinational unit examines one 32-bit single-precision word. It reports the operand's category as a one-hot code with six categories: zero, subnormal, normal, infinity, quiet NaN and signaling NaN. A mode bit selects which NaN convention applies. Under the 2008 convention a set top fraction bit marks a quiet NaN. Under the legacy convention the meaning of that bit is reversed.

A quiet request turns a signaling NaN into a quiet NaN on the result word and raises an invalid-operation flag in the same evaluation. The way the quiet bit changes depends on the mode. In legacy mode, clearing the quiet bit can leave an all-zero fraction, which would read as infinity. The unit repairs that case by setting the next fraction bit down. Any operand that is not a signaling NaN passes through unchanged and raises no flag. A signaling NaN with no quiet request also passes through unchanged.

Top module: `fpc_nan_unit`

## Requirements
- R1: An operand with exponent field 0 and fraction 0 is classed as zero (code bit 0) for either sign.
- R2: An operand with exponent field 0 and a nonzero fraction is classed as subnormal (code bit 1).
- R3: An operand whose exponent field is neither 0 nor 255 is classed as normal (code bit 2).
- R4: An operand with exponent field 255 and fraction 0 is classed as infinity (code bit 3).
- R5: An operand with exponent field 255 and a nonzero fraction is a NaN. It is signaling (code bit 5) when the mode bit XOR fraction bit 22 equals 1, and quiet (code bit 4) otherwise. Mode 1 is the 2008 convention and mode 0 is the legacy convention.
- R6: Exactly one bit of the 6-bit class code is set for every operand.
- R7: With mode 1, a quiet request on a signaling NaN sets fraction bit 22 of the result and raises the flag.
- R8: With mode 0, a quiet request on a signaling NaN clears fraction bit 22 of the result and raises the flag.
- R9: With mode 0, if clearing bit 22 would leave fraction bits 21..0 all zero, the result also has fraction bit 21 set, so the result is still a NaN.
- R10: A quiet request on an operand that is not a signaling NaN leaves the result equal to the operand, and the flag stays low.
- R11: Without a quiet request, the result equals the operand and the flag stays low, even for a signaling NaN.
- R12: Quieting leaves the sign bit, the exponent and fraction bits 21..0 unchanged, except for the R9 repair bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 32 | Operand word: sign bit 31, exponent bits 30..23, fraction bits 22..0 |
| nan2008_i | input | 1 | NaN convention: 1 selects 2008, 0 selects legacy |
| quiet_req_i | input | 1 | Request to quiet a signaling NaN |
| cls_o | output | 6 | One-hot class: bit 5 snan, 4 qnan, 3 inf, 2 normal, 1 subnormal, 0 zero |
| res_o | output | 32 | Result word, quieted or passed through |
| inv_o | output | 1 | Invalid-operation flag |

## Verification
Classification and quieting resolve in the same evaluation. On a signaling NaN with a request, the class code, the rewritten word and the flag must therefore all be consistent at once. The sharpest case is a legacy-mode operand whose only set fraction bit is the quiet bit. Here the classifier must report signaling NaN while the quieter clears that bit, repairs the word with bit 21 and raises the flag. The bench drives these words, such as 0x7FC00000 in legacy mode, alongside the same words in 2008 mode. It judges all three outputs against values worked out from the rules.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int unsigned DEF_EXP_W  = 8;
  localparam int unsigned DEF_FRAC_W = 23;
  localparam int unsigned CLS_W      = 6;
  // one-hot class bit positions (ordering is part of the output contract)
  localparam int unsigned CLS_ZERO   = 0;
  localparam int unsigned CLS_SUB    = 1;
  localparam int unsigned CLS_NORM   = 2;
  localparam int unsigned CLS_INF    = 3;
  localparam int unsigned CLS_QNAN   = 4;
  localparam int unsigned CLS_SNAN   = 5;
  typedef logic [CLS_W-1:0] cls_t;
endpackage

// File: rtl/fpc_decode.sv
module fpc_decode
  import fpc_pkg::*;
#(
  parameter int unsigned EXP_W  = DEF_EXP_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] op_i,
  input  logic              nan2008_i,
  output cls_t              cls_o,
  output logic              snan_o
);
  logic [EXP_W-1:0]  exp_fld;
  logic [FRAC_W-1:0] frac_fld;
  logic exp_ones, exp_none, frac_none, qbit, is_nan;

  always_comb begin
    exp_fld   = op_i[WORD_W-2 -: EXP_W];
    frac_fld  = op_i[FRAC_W-1:0];
    exp_ones  = &exp_fld;
    exp_none  = ~|exp_fld;
    frac_none = ~|frac_fld;
    qbit      = frac_fld[FRAC_W-1];
    is_nan    = exp_ones & ~frac_none;
    snan_o    = is_nan & (nan2008_i ^ qbit);
  end

  always_comb begin
    cls_o           = '0;
    cls_o[CLS_ZERO] = exp_none & frac_none;
    cls_o[CLS_SUB]  = exp_none & ~frac_none;
    cls_o[CLS_NORM] = ~exp_none & ~exp_ones;
    cls_o[CLS_INF]  = exp_ones & frac_none;
    cls_o[CLS_QNAN] = is_nan & ~snan_o;
    cls_o[CLS_SNAN] = snan_o;
  end
endmodule

// File: rtl/fpc_quiet.sv
module fpc_quiet
  import fpc_pkg::*;
#(
  parameter int unsigned EXP_W  = DEF_EXP_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W,
  localparam int unsigned QPOS   = FRAC_W - 1,
  localparam int unsigned RPOS   = FRAC_W - 2
) (
  input  logic [WORD_W-1:0] op_i,
  input  logic              nan2008_i,
  input  logic              fire_i,
  output logic [WORD_W-1:0] res_o
);
  logic low_none;

  always_comb begin
    low_none = ~|op_i[RPOS:0];
    res_o    = op_i;
    if (fire_i) begin
      if (nan2008_i) begin
        res_o[QPOS] = 1'b1;
      end else begin
        res_o[QPOS] = 1'b0;
        // keep the word a NaN when the quiet bit was the only fraction bit
        if (low_none) res_o[RPOS] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fpc_nan_unit.sv
module fpc_nan_unit
  import fpc_pkg::*;
#(
  parameter int unsigned EXP_W  = DEF_EXP_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] op_i,
  input  logic              nan2008_i,
  input  logic              quiet_req_i,
  output logic [CLS_W-1:0]  cls_o,
  output logic [WORD_W-1:0] res_o,
  output logic              inv_o
);
  logic snan;
  logic fire;

  fpc_decode #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_decode (
    .op_i      (op_i),
    .nan2008_i (nan2008_i),
    .cls_o     (cls_o),
    .snan_o    (snan)
  );

  assign fire  = quiet_req_i & snan;
  assign inv_o = fire;

  fpc_quiet #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_quiet (
    .op_i      (op_i),
    .nan2008_i (nan2008_i),
    .fire_i    (fire),
    .res_o     (res_o)
  );
endmodule

// File: rtl/fpc_nan_unit_chk.sv
module fpc_nan_unit_chk
  import fpc_pkg::*;
#(
  parameter int unsigned EXP_W  = DEF_EXP_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
  input logic [WORD_W-1:0] op_i,
  input logic              nan2008_i,
  input logic              quiet_req_i,
  input logic [CLS_W-1:0]  cls_o,
  input logic [WORD_W-1:0] res_o,
  input logic              inv_o
);
  always_comb begin
    assert_cls_onehot_R6: assert ($countones(cls_o) == 1)
      else $error("class code not one-hot");
    if (inv_o) begin
      assert_flag_src_R10: assert (quiet_req_i && cls_o[CLS_SNAN])
        else $error("flag without quiet request on signaling NaN");
      assert_sign_keep_R12: assert (res_o[WORD_W-1] == op_i[WORD_W-1])
        else $error("sign altered by quieting");
      assert_exp_keep_R12: assert (&res_o[WORD_W-2 -: EXP_W])
        else $error("quieted word lost its NaN exponent");
      if (nan2008_i) begin
        assert_qbit_set_R7: assert (res_o[FRAC_W-1])
          else $error("2008 quieting left bit 22 clear");
      end else begin
        assert_qbit_clr_R8: assert (!res_o[FRAC_W-1])
          else $error("legacy quieting left bit 22 set");
        assert_still_nan_R9: assert (|res_o[FRAC_W-1:0])
          else $error("legacy quieting collapsed to infinity");
      end
    end else begin
      assert_pass_R11: assert (res_o == op_i)
        else $error("result differs from operand without flag");
    end
  end
endmodule

bind fpc_nan_unit fpc_nan_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .op_i        (op_i),
  .nan2008_i   (nan2008_i),
  .quiet_req_i (quiet_req_i),
  .cls_o       (cls_o),
  .res_o       (res_o),
  .inv_o       (inv_o)
);

// File: tb/fpc_nan_unit_tb.sv
module fpc_nan_unit_tb;
  logic        clk;
  logic        rst_n;
  logic [31:0] op;
  logic        m2008;
  logic        qreq;
  logic [5:0]  cls;
  logic [31:0] res;
  logic        inv;
  int          n_chk;
  int          n_bad;
  bit          done;

  fpc_nan_unit u_dut (
    .op_i        (op),
    .nan2008_i   (m2008),
    .quiet_req_i (qreq),
    .cls_o       (cls),
    .res_o       (res),
    .inv_o       (inv)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  localparam logic [5:0] C_ZERO = 6'b000001;
  localparam logic [5:0] C_SUB  = 6'b000010;
  localparam logic [5:0] C_NORM = 6'b000100;
  localparam logic [5:0] C_INF  = 6'b001000;
  localparam logic [5:0] C_QNAN = 6'b010000;
  localparam logic [5:0] C_SNAN = 6'b100000;

  // {tag, mode, req, operand, class, result, flag}
  localparam int NV = 20;
  localparam logic [80:0] VEC [NV] = '{
    {8'd1,  1'b1, 1'b1, 32'h00000000, C_ZERO, 32'h00000000, 1'b0}, // R1
    {8'd1,  1'b0, 1'b0, 32'h80000000, C_ZERO, 32'h80000000, 1'b0}, // R1
    {8'd2,  1'b1, 1'b1, 32'h00000001, C_SUB,  32'h00000001, 1'b0}, // R2
    {8'd2,  1'b1, 1'b0, 32'h807FFFFF, C_SUB,  32'h807FFFFF, 1'b0}, // R2
    {8'd3,  1'b1, 1'b1, 32'h3F800000, C_NORM, 32'h3F800000, 1'b0}, // R3
    {8'd3,  1'b0, 1'b1, 32'h7F7FFFFF, C_NORM, 32'h7F7FFFFF, 1'b0}, // R3
    {8'd4,  1'b1, 1'b1, 32'h7F800000, C_INF,  32'h7F800000, 1'b0}, // R4
    {8'd4,  1'b0, 1'b1, 32'hFF800000, C_INF,  32'hFF800000, 1'b0}, // R4
    {8'd5,  1'b1, 1'b0, 32'h7FC00000, C_QNAN, 32'h7FC00000, 1'b0}, // R5
    {8'd11, 1'b1, 1'b0, 32'h7F800001, C_SNAN, 32'h7F800001, 1'b0}, // R11
    {8'd5,  1'b0, 1'b0, 32'h7FC00000, C_SNAN, 32'h7FC00000, 1'b0}, // R5
    {8'd5,  1'b0, 1'b0, 32'h7F800001, C_QNAN, 32'h7F800001, 1'b0}, // R5
    {8'd7,  1'b1, 1'b1, 32'h7F800001, C_SNAN, 32'h7FC00001, 1'b1}, // R7
    {8'd12, 1'b1, 1'b1, 32'hFFA5A5A5, C_SNAN, 32'hFFE5A5A5, 1'b1}, // R12
    {8'd9,  1'b0, 1'b1, 32'h7FC00000, C_SNAN, 32'h7FA00000, 1'b1}, // R9
    {8'd9,  1'b0, 1'b1, 32'hFFC00000, C_SNAN, 32'hFFA00000, 1'b1}, // R9
    {8'd8,  1'b0, 1'b1, 32'h7FE00000, C_SNAN, 32'h7FA00000, 1'b1}, // R8
    {8'd8,  1'b0, 1'b1, 32'h7FC00123, C_SNAN, 32'h7F800123, 1'b1}, // R8
    {8'd10, 1'b0, 1'b1, 32'h7F800001, C_QNAN, 32'h7F800001, 1'b0}, // R10
    {8'd10, 1'b1, 1'b1, 32'h7FC00001, C_QNAN, 32'h7FC00001, 1'b0}  // R10
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s op=%h act=%h exp=%h", tag, op, act, exp);
    end
  endtask

  task automatic apply(input logic m, input logic r, input logic [31:0] w);
    @(posedge clk);
    m2008 = m; qreq = r; op = w;
    @(negedge clk);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; op = '0; m2008 = 1'b1; qreq = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // idle state after reset: zero operand, no request (R1, R11)
    check("R1", {26'd0, cls}, {26'd0, C_ZERO});
    check("R11", {31'd0, inv}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      string t;
      apply(VEC[i][72], VEC[i][71], VEC[i][70:39]);
      t = $sformatf("R%0d", VEC[i][80:73]);
      check(t, {26'd0, cls}, {26'd0, VEC[i][38:33]});
      check(t, res, VEC[i][32:1]);
      check(t, {31'd0, inv}, {31'd0, VEC[i][0]});
    end

    // R7 / R12: 2008 quieting sweep, sign and low fraction kept
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < 22; k++) begin
        logic [31:0] w;
        w = {s[0], 8'hFF, 1'b0, 22'd1 << k};
        apply(1'b1, 1'b1, w);
        check("R7", res, w | 32'h00400000);
        check("R12", {31'd0, inv}, 32'd1);
      end
    end

    // R8 / R9 / R12: legacy quieting sweep, repair when low fraction empty
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < 23; k++) begin
        logic [31:0] w;
        logic [31:0] e;
        w = {s[0], 8'hFF, 1'b1, (k == 22) ? 22'd0 : (22'd1 << k)};
        e = w & ~32'h00400000;
        if (e[21:0] == 22'd0) e = e | 32'h00200000;
        apply(1'b0, 1'b1, w);
        check((k == 22) ? "R9" : "R8", res, e);
        check("R6", {26'd0, cls}, {26'd0, C_SNAN});
      end
    end

    // R6: exponent sweep in both modes, exactly one class bit
    for (int e = 0; e < 256; e += 17) begin
      apply(e[0], 1'b0, {1'b0, e[7:0], 23'h000400});
      check("R6", $countones(cls), 32'd1);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule